// File: doc/BRIEF.md
# Packet Offset Pattern Matcher

This block sits on a 64-bit packet stream in which each beat carries a valid strobe and separate start and end markers. It looks for a byte string of fixed length at a fixed byte distance from the first byte of every packet. The offset, the string length and the string itself are set by parameters when the block is built. The stream leaves the block unchanged but late. With the delayed start beat of each packet, the block raises a one-bit flag that says whether that packet holds the string. A downstream stage therefore knows the verdict before any of the packet's payload reaches it.

The delay is a chain of beat registers. The chain moves one place for each accepted input beat. When a start beat reaches the oldest slot, the sixteen slots hold that beat and the fifteen beats after it. The comparison is made across this window. The string may begin in any byte lane and may cross a beat boundary.

Top module: `pkt_offset_matcher`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `out_match` are low until the block has accepted enough beats to emit one.
- R2: Each emitted beat carries exactly the 64-bit data, start bit and end bit of the input beat it stands for. Beats leave in arrival order.
- R3: An accepted beat is emitted on the clock edge at which the DEPTH-th (default 16) later input beat is accepted. `out_valid` is high only in the cycle after such an edge.
- R4: A cycle with `in_valid` low produces `out_valid` low in the next cycle. It also leaves `out_data` unchanged.
- R5: Byte k of a packet is bits [8*(k%8)+7 : 8*(k%8)] of the packet's beat k/8, counted from its start beat as beat 0. Pattern byte i is `PATTERN[8*i+7:8*i]`. `out_match` is high on an emitted start beat exactly when packet byte OFFSET_BYTES+i equals pattern byte i for every i below PAT_LEN. The defaults are OFFSET_BYTES=21, PAT_LEN=6 and PATTERN=48'hA1B2C3D4E5F6.
- R6: A pattern that starts in one beat and ends in the next is detected. The defaults place it in lanes 5 to 7 of beat 2 and lanes 0 to 2 of beat 3.
- R7: If the packet's end bit sits on a beat before the beat that holds the last pattern byte, `out_match` is low for that packet, even when the following bytes of the stream would complete the pattern. An end bit on the beat that holds the last pattern byte does not block a match.
- R8: `out_match` is low on every emitted beat that is not a start beat and in every cycle with `out_valid` low.
- R9: A packet whose start beat directly follows the previous packet's end beat is judged only on its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_data | input | 64 | Input beat bytes, lane 0 in bits 7:0 |
| in_sop | input | 1 | Input beat is first of packet |
| in_eop | input | 1 | Input beat is last of packet |
| out_valid | output | 1 | Emitted beat present |
| out_data | output | 64 | Emitted beat bytes |
| out_sop | output | 1 | Emitted beat is first of packet |
| out_eop | output | 1 | Emitted beat is last of packet |
| out_match | output | 1 | Pattern found in this packet, on its start beat only |

## Verification
Two things can land on the same cycle: one packet's verdict and the end of the window of the previous, shorter packet. A packet can end on beat 2, with its pattern bytes only partly present, while the next packet starts at once and begins with the missing bytes. Such a pair is sent on purpose. The first packet must then show `out_match` low and the second high. The bench builds its expected stream from a queue of every accepted input beat. It works out each verdict byte by byte from the requirement text and compares data, markers and flag on every cycle. Random idle gaps and back-to-back packets are mixed in throughout.

// File: rtl/pom_pkg.sv
// Shared beat type for the packet offset matcher.
// Assumes a fixed lane count of eight bytes per beat.
package pom_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = BEAT_BYTES * 8;

    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              eop;
        logic [BEAT_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/pom_delay_line.sv
// Delay chain of DEPTH beat slots that shifts only when adv is high.
// Slot DEPTH-1 takes the new beat; slot 0 holds the oldest one.
// Assumes the caller only needs every slot exposed, not a ready handshake.
module pom_delay_line
    import pom_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  beat_t                   din,
    output beat_t [DEPTH-1:0]       taps
);
    beat_t [DEPTH-1:0] slot;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == DEPTH - 1) begin : g_head
            // Newest slot loads the incoming beat
            always_ff @(posedge clk) begin
                if (!rst_n)   slot[g] <= '0;
                else if (adv) slot[g] <= din;
            end
        end else begin : g_body
            // Older slots take their younger neighbour
            always_ff @(posedge clk) begin
                if (!rst_n)   slot[g] <= '0;
                else if (adv) slot[g] <= slot[g+1];
            end
        end
    end

    assign taps = slot;
endmodule

// File: rtl/pom_window_cmp.sv
// Compares the byte string against the window whose slot 0 is a start beat.
// A hit needs every pattern byte equal and no end marker in the beats before
// the beat that holds the last pattern byte. Purely combinational.
module pom_window_cmp
    import pom_pkg::*;
#(
    parameter int                    DEPTH        = 16,
    parameter int                    OFFSET_BYTES = 21,
    parameter int                    PAT_LEN      = 6,
    parameter logic [8*PAT_LEN-1:0]  PATTERN      = 48'hA1B2C3D4E5F6
) (
    input  beat_t [DEPTH-1:0] win,
    output logic              hit
);
    localparam int LAST_BEAT = (OFFSET_BYTES + PAT_LEN - 1) / BEAT_BYTES;

    logic [PAT_LEN-1:0] byte_eq;
    logic [DEPTH-1:0]   cut;

    // One byte comparator per pattern byte, lane picked at build time
    for (genvar i = 0; i < PAT_LEN; i++) begin : g_byte
        localparam int P = OFFSET_BYTES + i;
        assign byte_eq[i] = (win[P / BEAT_BYTES].data[8*(P % BEAT_BYTES) +: 8]
                             == PATTERN[8*i +: 8]);
    end

    // Beats up to the last pattern beat must be present; earlier ones must not end the packet
    for (genvar j = 0; j < DEPTH; j++) begin : g_cut
        if (j < LAST_BEAT) begin : g_pre
            assign cut[j] = win[j].eop || !win[j].vld;
        end else if (j == LAST_BEAT) begin : g_last
            assign cut[j] = !win[j].vld;
        end else begin : g_after
            assign cut[j] = 1'b0;
        end
    end

    assign hit = win[0].vld && win[0].sop && (&byte_eq) && !(|cut);

    logic unused_win_bits;
    assign unused_win_bits = ^win;
endmodule

// File: rtl/pkt_offset_matcher.sv
// Top of the packet offset matcher. Delays the stream by DEPTH accepted beats
// and tags each emitted start beat with the verdict for its packet.
// Assumes OFFSET_BYTES + PAT_LEN <= DEPTH * 8 and no backpressure downstream.
module pkt_offset_matcher
    import pom_pkg::*;
#(
    parameter int                    DEPTH        = 16,
    parameter int                    OFFSET_BYTES = 21,
    parameter int                    PAT_LEN      = 6,
    parameter logic [8*PAT_LEN-1:0]  PATTERN      = 48'hA1B2C3D4E5F6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [BEAT_W-1:0]    in_data,
    input  logic                 in_sop,
    input  logic                 in_eop,
    output logic                 out_valid,
    output logic [BEAT_W-1:0]    out_data,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic                 out_match
);
    localparam int LAST_BEAT = (OFFSET_BYTES + PAT_LEN - 1) / BEAT_BYTES;
    localparam int CW        = $clog2(DEPTH + 2);

    beat_t             in_beat;
    beat_t [DEPTH-1:0] win;
    logic              hit;
    logic [CW-1:0]     fill_cnt;

    // Pack the input pins into one beat record
    always_comb begin
        in_beat.vld  = in_valid;
        in_beat.sop  = in_sop;
        in_beat.eop  = in_eop;
        in_beat.data = in_data;
    end

    pom_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (in_valid),
        .din  (in_beat),
        .taps (win)
    );

    pom_window_cmp #(
        .DEPTH       (DEPTH),
        .OFFSET_BYTES(OFFSET_BYTES),
        .PAT_LEN     (PAT_LEN),
        .PATTERN     (PATTERN)
    ) u_cmp (
        .win(win),
        .hit(hit)
    );

    // Emit the oldest slot as it is pushed out by a new beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_match <= 1'b0;
        end else begin
            out_valid <= in_valid && win[0].vld;
            out_match <= in_valid && hit;
            if (in_valid) begin
                out_data <= win[0].data;
                out_sop  <= win[0].sop;
                out_eop  <= win[0].eop;
            end
        end
    end

    // Saturating count of accepted beats, used only to check output timing
    always_ff @(posedge clk) begin
        if (!rst_n)                                  fill_cnt <= '0;
        else if (in_valid && fill_cnt != CW'(DEPTH + 1)) fill_cnt <= fill_cnt + 1'b1;
    end

    // R8
    match_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_match |-> (out_valid && out_sop));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R3
    latency_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fill_cnt == CW'(DEPTH + 1)));

    if (LAST_BEAT > 0) begin : g_eop_chk
        // R7
        short_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_match |-> !out_eop);
    end
endmodule

// File: tb/sim_pkt_offset_matcher.sv
module sim_pkt_offset_matcher;
    localparam int DEPTH = 16;
    localparam int OFF   = 21;
    localparam int PL    = 6;
    localparam logic [8*PL-1:0] PAT = 48'hA1B2C3D4E5F6;
    localparam int MAXB  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_match;

    always #5 clk = ~clk;

    pkt_offset_matcher u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_match(out_match)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] bd [MAXB];
    bit          bs [MAXB];
    bit          be [MAXB];
    int          n_in = 0;

    bit          pend_chk = 1'b0;
    bit          pend_vld = 1'b0;
    int          pend_idx = 0;
    logic [63:0] last_data = '0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Verdict from the requirement text: byte k of packet -> beat k/8, lane k%8
    function automatic bit exp_match(input int s);
        int last_b;
        if (!bs[s]) return 1'b0;
        last_b = s + (OFF + PL - 1) / 8;
        for (int b = s; b < last_b; b++) if (be[b]) return 1'b0;
        for (int i = 0; i < PL; i++) begin
            int p = OFF + i;
            if (bd[s + p/8][8*(p%8) +: 8] != PAT[8*i +: 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_pending();
        if (!pend_chk) return;
        chk(out_valid == pend_vld, "R3 R4 out_valid", 64'(out_valid), 64'(pend_vld));
        if (pend_vld) begin
            bit em = exp_match(pend_idx);
            chk(out_data == bd[pend_idx], "R2 out_data", out_data, bd[pend_idx]);
            chk(out_sop == bs[pend_idx], "R2 out_sop", 64'(out_sop), 64'(bs[pend_idx]));
            chk(out_eop == be[pend_idx], "R2 out_eop", 64'(out_eop), 64'(be[pend_idx]));
            if (bs[pend_idx])
                chk(out_match == em, "R5 R6 R7 R9 out_match on start beat", 64'(out_match), 64'(em));
            else
                chk(out_match == 1'b0, "R8 out_match off start beat", 64'(out_match), 64'd0);
            last_data = out_data;
        end else begin
            chk(out_match == 1'b0, "R8 out_match while idle", 64'(out_match), 64'd0);
            chk(out_data == last_data, "R4 out_data held", out_data, last_data);
        end
    endtask

    task automatic put(input bit v, input logic [63:0] d, input bit s, input bit e);
        @(negedge clk);
        check_pending();
        in_valid = v; in_data = d; in_sop = s; in_eop = e;
        pend_chk = 1'b1;
        if (v) begin
            pend_vld = (n_in >= DEPTH);
            pend_idx = n_in - DEPTH;
            bd[n_in] = d; bs[n_in] = s; be[n_in] = e;
            n_in++;
        end else begin
            pend_vld = 1'b0;
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Build a packet; optionally plant the pattern, else plant it with the last byte flipped
    task automatic send_pkt(input int len, input bit with_pat, input bit gaps);
        logic [63:0] pk [32];
        for (int b = 0; b < len; b++) pk[b] = rnd64();
        for (int i = 0; i < PL; i++) begin
            int p = OFF + i;
            if (p/8 < len) pk[p/8][8*(p%8) +: 8] = PAT[8*i +: 8];
        end
        if (!with_pat && (OFF + PL - 1)/8 < len)
            pk[(OFF+PL-1)/8][8*((OFF+PL-1)%8) +: 8] = ~PAT[8*(PL-1) +: 8];
        for (int b = 0; b < len; b++) begin
            if (gaps) for (int k = 0; k < int'($urandom_range(0, 2)); k++) put(1'b0, '0, 1'b0, 1'b0);
            put(1'b1, pk[b], b == 0, b == len - 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        chk(out_match == 1'b0, "R1 out_match in reset", 64'(out_match), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);

        send_pkt(6, 1'b1, 1'b0);          // R5 R6: pattern across beats 2 and 3
        send_pkt(6, 1'b0, 1'b0);          // R5: last byte wrong
        // R7 R9: first packet ends on beat 2; next one starts with the missing bytes
        begin
            logic [63:0] a2, b0;
            a2 = rnd64();
            for (int i = 0; i < 3; i++) a2[8*(5+i) +: 8] = PAT[8*i +: 8];
            b0 = rnd64();
            for (int i = 0; i < 3; i++) b0[8*i +: 8] = PAT[8*(3+i) +: 8];
            put(1'b1, rnd64(), 1'b1, 1'b0);
            put(1'b1, rnd64(), 1'b0, 1'b0);
            put(1'b1, a2,      1'b0, 1'b1);
            put(1'b1, b0,      1'b1, 1'b0);
            put(1'b1, rnd64(), 1'b0, 1'b0);
            put(1'b1, a2,      1'b0, 1'b0);
            put(1'b1, b0,      1'b0, 1'b1);   // second packet holds full pattern
        end
        send_pkt(4, 1'b1, 1'b0);          // R7: end on the last pattern beat
        send_pkt(1, 1'b1, 1'b0);          // single-beat packets
        send_pkt(1, 1'b0, 1'b1);
        send_pkt(2, 1'b1, 1'b0);
        for (int n = 0; n < 40; n++)
            send_pkt(int'($urandom_range(1, 12)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        for (int n = 0; n < 3; n++) send_pkt(8, 1'b0, 1'b0);   // push the tail out
        put(1'b0, '0, 1'b0, 1'b0);
        put(1'b0, '0, 1'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule